// File: doc/BRIEF.md
# 8-bit ALU with Selective Status Update

This block is the arithmetic and status stage of a small 8-bit processor datapath. It takes two operands, a 4-bit operation code and the current status byte. It returns three things: the operation result, a write enable for the destination register, and the status byte that the surrounding core should store next. It has no storage of its own. The core registers the status byte and feeds it back on the next instruction.

The operations are addition, addition with carry, subtraction, subtraction with borrow, bitwise AND, OR and XOR, a logical shift right by one, and an unsigned compare. Each operation rewrites only its own group of flags and leaves the other flags at their incoming values. That lets a compare sit between an arithmetic step and a branch without losing the carry.

The input-received flag is controlled only by a separate set/clear pair, so an input port can mark new data without going through the ALU. Operation codes with no defined function pass the status through and request no write.

Top module: `alu8_status_unit`

## Requirements
- R1: The status byte holds, from bit 7 down, C (carry/borrow), V (signed overflow), Z (zero or equal), N (result bit 7), G (greater), L (less) and I (input received); bit 0 is passed from status_i to status_o unchanged.
- R2: Op codes 0 (add) and 1 (add with carry) give result = a + b (+ incoming C for op 1) modulo 256. C is the carry out, V is two's-complement overflow, Z is 1 when the result is zero and N is result bit 7. G and L keep their incoming values.
- R3: Op codes 2 (sub) and 3 (sub with borrow) give result = a - b (- incoming C for op 3) modulo 256. C=1 means the true difference was negative (a borrow). V, Z and N follow R2's rules, and G and L keep their values.
- R4: Op codes 4 (AND), 5 (OR) and 6 (XOR) give the bitwise result and update only Z and N. C, V, G and L keep their values.
- R5: Op code 7 (shift right) gives result = a >> 1 with a zero entering bit 7. C takes the old a bit 0, Z and N follow the result, and V, G and L keep their values.
- R6: Op code 8 (compare) treats a and b as unsigned. It sets Z when they are equal, G when a > b and L when a < b, so exactly one of the three is 1. C, V and N keep their values, there is no destination write, and result is 0.
- R7: Op codes 0 to 7 assert wr_en_o. Op codes 8 to 15 deassert it.
- R8: Op codes 9 to 15 give result 0 and leave bits 7 to 2 of the status unchanged.
- R9: No operation changes I. The next I is 1 when iflag_set_i=1; it is 0 when only iflag_clr_i=1; otherwise it keeps its incoming value. Set wins over clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| op_i | input | 4 | Operation code (0 add, 1 adc, 2 sub, 3 sbb, 4 and, 5 or, 6 xor, 7 shr, 8 cmp, 9-15 none) |
| status_i | input | 8 | Current status byte |
| iflag_set_i | input | 1 | Set the input-received flag |
| iflag_clr_i | input | 1 | Clear the input-received flag |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| status_o | output | 8 | Next status byte |

## Verification
The hardest cases to reach are the carry-dependent paths: add with an incoming carry that wraps exactly at 255, and subtract with borrow where b plus the incoming borrow exceeds a, including b=255 with borrow set. A further hard case is making sure that flags outside an operation's group are held rather than cleared. The bench sweeps every (a, b) pair for all sixteen operation codes. It derives the incoming status byte and the set/clear pair from a mix of a, b and the op code, so both carry values and many patterns of held flags appear at every operand pair. Expected values come from signed and unsigned integer arithmetic in the bench rather than from complement-and-add.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_SHR = 4'd7,
    OP_CMP = 4'd8
  } alu_op_e;

  localparam int STW   = 8;
  localparam int FLG_C = 7;
  localparam int FLG_V = 6;
  localparam int FLG_Z = 5;
  localparam int FLG_N = 4;
  localparam int FLG_G = 3;
  localparam int FLG_L = 2;
  localparam int FLG_I = 1;

  // Which of the ALU-owned flags an op code rewrites.
  function automatic logic [STW-1:0] update_mask(input logic [3:0] op);
    logic [STW-1:0] m;
    m = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        m[FLG_C] = 1'b1; m[FLG_V] = 1'b1; m[FLG_Z] = 1'b1; m[FLG_N] = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        m[FLG_Z] = 1'b1; m[FLG_N] = 1'b1;
      end
      OP_SHR: begin
        m[FLG_C] = 1'b1; m[FLG_Z] = 1'b1; m[FLG_N] = 1'b1;
      end
      OP_CMP: begin
        m[FLG_Z] = 1'b1; m[FLG_G] = 1'b1; m[FLG_L] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic writes_dest(input logic [3:0] op);
    return (op <= OP_SHR);
  endfunction

  function automatic logic is_arith(input logic [3:0] op);
    return (op <= OP_SBB);
  endfunction

  // Two's-complement overflow of an addition, given the addend actually used.
  function automatic logic add_overflow(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         chain_i,
  input  logic         flag_c_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  import alu8_pkg::*;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   wide;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    cin     = sub_i ? ~(chain_i & flag_c_i) : (chain_i & flag_c_i);
    wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum_o   = wide[W-1:0];
    carry_o = sub_i ? ~wide[W] : wide[W];
    ovf_o   = add_overflow(a_i[W-1], b_eff[W-1], wide[W-1]);
  end

  logic [W+1:0] subtrahend;
  always_comb begin
    subtrahend = {2'b00, b_i} + {{(W+1){1'b0}}, chain_i & flag_c_i};
    if (sub_i) begin
      // R3
      borrow_flag_chk: assert (carry_o == ({2'b00, a_i} < subtrahend))
        else $error("borrow flag disagrees with unsigned compare");
    end
  end

endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o,
  output logic         shift_out_o
);

  always_comb begin
    shift_out_o = 1'b0;
    case (sel_i)
      2'd0: res_o = a_i & b_i;
      2'd1: res_o = a_i | b_i;
      2'd2: res_o = a_i ^ b_i;
      default: begin
        res_o       = {1'b0, a_i[W-1:1]};
        shift_out_o = a_i[0];
      end
    endcase
  end

endmodule

// File: rtl/alu8_cmp.sv
`timescale 1ns/1ps
module alu8_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o,
  output logic         gt_o,
  output logic         lt_o
);

  always_comb begin
    eq_o = (a_i == b_i);
    gt_o = (a_i > b_i);
    lt_o = (a_i < b_i);
  end

  always_comb begin
    // R6
    cmp_onehot_chk: assert ($countones({eq_o, gt_o, lt_o}) == 1)
      else $error("compare outcome not exactly one of eq/gt/lt");
  end

endmodule

// File: rtl/alu8_status_unit.sv
`timescale 1ns/1ps
module alu8_status_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic [7:0]   status_i,
  input  logic         iflag_set_i,
  input  logic         iflag_clr_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [7:0]   status_o
);
  import alu8_pkg::*;

  // Named internal events for assertions.
  logic [W-1:0]   arith_res, logic_res;
  logic           arith_c, arith_v, shr_c;
  logic           cmp_eq, cmp_gt, cmp_lt;
  logic           op_arith, op_cmp, op_shr;
  logic [STW-1:0] fresh_flags, upd;
  logic           i_next;

  assign op_arith = is_arith(op_i);
  assign op_cmp   = (op_i == OP_CMP);
  assign op_shr   = (op_i == OP_SHR);

  alu8_arith #(.W(W)) u_arith (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (op_i[1]),
    .chain_i  (op_i[0]),
    .flag_c_i (status_i[FLG_C]),
    .sum_o    (arith_res),
    .carry_o  (arith_c),
    .ovf_o    (arith_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i         (a_i),
    .b_i         (b_i),
    .sel_i       (op_i[1:0]),
    .res_o       (logic_res),
    .shift_out_o (shr_c)
  );

  alu8_cmp #(.W(W)) u_cmp (
    .a_i (a_i),
    .b_i (b_i),
    .eq_o(cmp_eq),
    .gt_o(cmp_gt),
    .lt_o(cmp_lt)
  );

  always_comb begin
    wr_en_o = writes_dest(op_i);
    if (op_arith)     result_o = arith_res;
    else if (wr_en_o) result_o = logic_res;
    else              result_o = '0;
  end

  always_comb begin
    fresh_flags        = '0;
    fresh_flags[FLG_C] = op_shr ? shr_c : arith_c;
    fresh_flags[FLG_V] = arith_v;
    fresh_flags[FLG_Z] = op_cmp ? cmp_eq : (result_o == '0);
    fresh_flags[FLG_N] = result_o[W-1];
    fresh_flags[FLG_G] = cmp_gt;
    fresh_flags[FLG_L] = cmp_lt;
    upd                = update_mask(op_i);
    if (iflag_set_i)      i_next = 1'b1;
    else if (iflag_clr_i) i_next = 1'b0;
    else                  i_next = status_i[FLG_I];
  end

  for (genvar k = 0; k < STW; k++) begin : g_flag
    if (k == FLG_I) begin : g_in
      assign status_o[k] = i_next;
    end else begin : g_alu
      assign status_o[k] = upd[k] ? fresh_flags[k] : status_i[k];
    end
  end

  always_comb begin
    if (!iflag_set_i && !iflag_clr_i) begin
      // R9
      iflag_hold_chk: assert (status_o[FLG_I] == status_i[FLG_I])
        else $error("input flag moved without control");
    end
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
      // R4
      logic_keep_chk: assert (status_o[FLG_C] == status_i[FLG_C] &&
                              status_o[FLG_V] == status_i[FLG_V] &&
                              status_o[FLG_G] == status_i[FLG_G] &&
                              status_o[FLG_L] == status_i[FLG_L])
        else $error("logic op disturbed a held flag");
    end
    if (op_shr) begin
      // R5
      shr_edge_chk: assert (result_o[W-1] == 1'b0 && status_o[FLG_C] == a_i[0])
        else $error("shift right edge bits wrong");
    end
    if (op_i > OP_CMP) begin
      // R8
      idle_keep_chk: assert (!wr_en_o && result_o == '0 &&
                             status_o[7:2] == status_i[7:2])
        else $error("undefined op changed outputs");
    end
  end

endmodule

// File: tb/alu8_status_unit_tb.sv
`timescale 1ns/1ps
module alu8_status_unit_tb_top;

  logic       clk = 1'b0;
  logic [7:0] a, b, st, res, st_o;
  logic [3:0] op;
  logic       iset, iclr, wr;
  int         total = 0;
  int         bad   = 0;
  bit         done  = 1'b0;

  always #5 clk = ~clk;

  alu8_status_unit dut_i (
    .a_i(a), .b_i(b), .op_i(op), .status_i(st),
    .iflag_set_i(iset), .iflag_clr_i(iclr),
    .result_o(res), .wr_en_o(wr), .status_o(st_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s op=%0d a=%0d b=%0d st=%02h actual=%0h expected=%0h",
               req, op, a, b, st, act, exp);
    end
  endtask

  // Reference model built from integer arithmetic.
  task automatic model(output int er, output bit ew, output int es);
    int ua, ub, sa, sb, cin, wide, sr;
    bit c, v, z, n, g, l;
    ua = a; ub = b;
    sa = (ua > 127) ? ua - 256 : ua;
    sb = (ub > 127) ? ub - 256 : ub;
    cin = st[7];
    c = st[7]; v = st[6]; z = st[5]; n = st[4]; g = st[3]; l = st[2];
    er = 0; ew = (op < 8);
    case (op)
      0, 1: begin
        wide = ua + ub + ((op == 1) ? cin : 0);
        sr   = sa + sb + ((op == 1) ? cin : 0);
        er = wide % 256; c = (wide > 255); v = (sr > 127 || sr < -128);
        z = (er == 0); n = (er >= 128);
      end
      2, 3: begin
        wide = ua - ub - ((op == 3) ? cin : 0);
        sr   = sa - sb - ((op == 3) ? cin : 0);
        er = (wide + 512) % 256; c = (wide < 0); v = (sr > 127 || sr < -128);
        z = (er == 0); n = (er >= 128);
      end
      4, 5, 6: begin
        er = (op == 4) ? int'(a & b) : (op == 5) ? int'(a | b) : int'(a ^ b);
        z = (er == 0); n = (er >= 128);
      end
      7: begin
        er = ua / 2; c = ua % 2; z = (er == 0); n = 0;
      end
      8: begin
        z = (ua == ub); g = (ua > ub); l = (ua < ub);
      end
      default: ;
    endcase
    es = {c, v, z, n, g, l, (iset ? 1'b1 : (iclr ? 1'b0 : st[1])), st[0]};
  endtask

  function automatic string req_of(input int o);
    case (o)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5, 6: return "R4";
      7:       return "R5";
      8:       return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    int er, es;
    bit ew;
    // R1 layout: 0x80 + 0x80 -> result 0, C V Z set -> status 0xE0
    op = 4'd0; a = 8'h80; b = 8'h80; st = 8'h00; iset = 0; iclr = 0;
    #1;
    check(res == 8'h00, "R1", res, 0);
    check(st_o == 8'hE0, "R1", st_o, 8'hE0);
    // R1 bit 0 passthrough on a logic op
    op = 4'd4; a = 8'h0F; b = 8'hF0; st = 8'h01; #1;
    check(st_o == 8'h21, "R1", st_o, 8'h21);
    // R9 set beats clear, clear alone, ops leave I alone
    op = 4'd0; a = 8'h01; b = 8'h01; st = 8'h00; iset = 1; iclr = 1; #1;
    check(st_o[1] == 1'b1, "R9", st_o[1], 1);
    st = 8'h02; iset = 0; iclr = 1; #1;
    check(st_o[1] == 1'b0, "R9", st_o[1], 0);
    iclr = 0; op = 4'd8; #1;
    check(st_o[1] == 1'b1, "R9", st_o[1], 1);
    // R3 sbb corner: 0 - 255 - 1 = 0 with borrow
    op = 4'd3; a = 8'h00; b = 8'hFF; st = 8'h80; #1;
    check(res == 8'h00 && st_o[7], "R3", {st_o[7], res}, 9'h100);
    // R2 adc wrap: 255 + 0 + 1 = 0 with carry
    op = 4'd1; a = 8'hFF; b = 8'h00; st = 8'h80; #1;
    check(res == 8'h00 && st_o[7] && st_o[5], "R2", st_o, 8'hA0);

    // Exhaustive sweep of every op code and operand pair.
    for (int o = 0; o < 16; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          op = o[3:0]; a = x[7:0]; b = y[7:0];
          st = 8'((x * 7) ^ (y * 13) ^ (o * 37));
          iset = ((x ^ y) % 5) == 0;
          iclr = ((x + y) % 3) == 0;
          #1;
          model(er, ew, es);
          check(int'(res) == er, req_of(o), res, er);
          check(wr == ew, "R7", wr, ew);
          check(int'(st_o) == es, (o == 0) ? "R9" : req_of(o), st_o, es);
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule